// File: doc/BRIEF.md
# Accelerator Port Soft-Reset Controller

This block owns the soft-reset control of one accelerator port. Software writes a single 64-bit control word to put the port into reset or take it out. A hardware acknowledge flag in the same word reports when the reset has taken effect. The port leaves power-on reset held in soft reset. While it is held, the block refuses new requests and fences the accelerator off from the host's MMIO path.

The acknowledge is not raised as soon as reset is asserted. The block keeps an up/down count of requests that were accepted on the port but have not yet completed. It also runs a timer from the moment reset is entered. The acknowledge goes high only when the count has reached zero and the timer has covered the minimum pulse width. Software can therefore poll one register to learn that the port is quiet and that the accelerator has been held in reset for long enough.

Top module: `port_rst_ctrl`

## Requirements
- R1: After power-on reset the control word reads 0x1: the reset flag is 1 and the acknowledge is 0. `acc_rst_o` is high.
- R2: A control write sets the reset flag to bit 0 of the written word on the following clock edge. `acc_rst_o` follows the flag.
- R3: The control word reads back combinationally as follows: the reset flag is at bit 0, the acknowledge is at bit 4, and every other bit is 0.
- R4: The acknowledge is 1 only while the reset flag is 1. With no requests outstanding, it rises on the (MIN_PULSE+1)-th clock edge after the edge that set the reset flag.
- R5: While requests are outstanding, the acknowledge stays 0 however long reset is held. It rises on the edge after the count reaches zero, provided the pulse width has elapsed.
- R6: `req_accept_o` is 0 while the reset flag is 1, and also while the outstanding count is at its maximum of 2^CNT_W-1. Otherwise it equals `req_issue_i`.
- R7: A write that clears the reset flag also clears the acknowledge on the same clock edge.
- R8: Bit 4 of a control write is ignored. The acknowledge is set only by hardware.
- R9: The pulse-width timer restarts on every 0-to-1 change of the reset flag. Writing 1 while the flag is already 1 does not restart it and does not drop the acknowledge.
- R10: While the reset flag is 1, `acc_rd_o` and `acc_wr_o` are 0, `host_rdata_o` is 0, and the downstream address and data are 0. Otherwise host strobes, address, write data and read data pass straight through.
- R11: A completion strobe while the outstanding count is zero is ignored, so the count never wraps below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| csr_wr_i | input | 1 | Control register write strobe |
| csr_wdata_i | input | 64 | Control register write data |
| csr_rdata_o | output | 64 | Control register read data |
| req_issue_i | input | 1 | A request wants to enter the port |
| req_done_i | input | 1 | An outstanding request has completed |
| req_accept_o | output | 1 | The issued request is accepted this cycle |
| host_rd_i | input | 1 | Host MMIO read strobe |
| host_wr_i | input | 1 | Host MMIO write strobe |
| host_addr_i | input | ADDR_W | Host MMIO address |
| host_wdata_i | input | DATA_W | Host MMIO write data |
| host_rdata_o | output | DATA_W | Host MMIO read data |
| acc_rd_o | output | 1 | Accelerator read strobe |
| acc_wr_o | output | 1 | Accelerator write strobe |
| acc_addr_o | output | ADDR_W | Accelerator address |
| acc_wdata_o | output | DATA_W | Accelerator write data |
| acc_rdata_i | input | DATA_W | Accelerator read data |
| acc_rst_o | output | 1 | Soft reset to the accelerator |

## Verification
The bench goes after the acknowledge timing at its exact edge. A design that counted the pulse one cycle short or long would raise the acknowledge at the wrong edge. A design that ignored the drain would raise it while three requests were still in flight. The bench rewrites 1 onto an already-set flag and re-enters reset just after leaving it. A timer keyed to writes rather than to the flag's rising edge would drop or delay the acknowledge. It also strobes completions on an empty count and issues requests into a full count. Either would wrap a careless counter, and the acknowledge would never come back.

// File: rtl/prc_pkg.sv
package prc_pkg;

    localparam int CTRL_W       = 64;
    localparam int CTRL_RST_POS = 0;
    localparam int CTRL_ACK_POS = 4;

    function automatic logic [CTRL_W-1:0] ctrl_word(input logic rst, input logic ack);
        logic [CTRL_W-1:0] w;
        w               = '0;
        w[CTRL_RST_POS] = rst;
        w[CTRL_ACK_POS] = ack;
        return w;
    endfunction

endpackage

// File: rtl/prc_drain_tracker.sv
module prc_drain_tracker #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic issue_i,
    input  logic done_i,
    output logic accept_o,
    output logic idle_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } trk_t;

    trk_t trk_d, trk_q;
    logic full;
    logic dec;

    always_comb begin
        full     = &trk_q.cnt;
        accept_o = issue_i && !hold_i && !full;
        dec      = done_i && (trk_q.cnt != '0);
        trk_d    = trk_q;
        if (accept_o && !dec) begin
            trk_d.cnt = trk_q.cnt + 1'b1;
        end else if (dec && !accept_o) begin
            trk_d.cnt = trk_q.cnt - 1'b1;
        end
        idle_o = (trk_q.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_q.cnt == '0 && !issue_i) |=> (trk_q.cnt == '0));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (&trk_q.cnt && !done_i) |=> (&trk_q.cnt));

endmodule

// File: rtl/prc_pulse_timer.sv
module prc_pulse_timer #(
    parameter int MIN_PULSE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    output logic elapsed_o
);

    localparam int TMR_W = $clog2(MIN_PULSE + 1);
    localparam logic [TMR_W-1:0] TMR_TOP = TMR_W'(MIN_PULSE);

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!hold_i) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt != TMR_TOP) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
        elapsed_o = (tmr_q.cnt == TMR_TOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assert_timer_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_i |=> !elapsed_o);

endmodule

// File: rtl/prc_mmio_gate.sv
module prc_mmio_gate #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 64
) (
    input  logic              block_i,
    input  logic              host_rd_i,
    input  logic              host_wr_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic [DATA_W-1:0] host_rdata_o,
    output logic              acc_rd_o,
    output logic              acc_wr_o,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic [DATA_W-1:0] acc_wdata_o,
    input  logic [DATA_W-1:0] acc_rdata_i
);

    always_comb begin
        if (block_i) begin
            acc_rd_o     = 1'b0;
            acc_wr_o     = 1'b0;
            acc_addr_o   = '0;
            acc_wdata_o  = '0;
            host_rdata_o = '0;
        end else begin
            acc_rd_o     = host_rd_i;
            acc_wr_o     = host_wr_i;
            acc_addr_o   = host_addr_i;
            acc_wdata_o  = host_wdata_i;
            host_rdata_o = acc_rdata_i;
        end
    end

endmodule

// File: rtl/port_rst_ctrl.sv
module port_rst_ctrl #(
    parameter int MIN_PULSE = 16,
    parameter int CNT_W     = 4,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      csr_wr_i,
    input  logic [prc_pkg::CTRL_W-1:0] csr_wdata_i,
    output logic [prc_pkg::CTRL_W-1:0] csr_rdata_o,
    input  logic                      req_issue_i,
    input  logic                      req_done_i,
    output logic                      req_accept_o,
    input  logic                      host_rd_i,
    input  logic                      host_wr_i,
    input  logic [ADDR_W-1:0]         host_addr_i,
    input  logic [DATA_W-1:0]         host_wdata_i,
    output logic [DATA_W-1:0]         host_rdata_o,
    output logic                      acc_rd_o,
    output logic                      acc_wr_o,
    output logic [ADDR_W-1:0]         acc_addr_o,
    output logic [DATA_W-1:0]         acc_wdata_o,
    input  logic [DATA_W-1:0]         acc_rdata_i,
    output logic                      acc_rst_o
);

    import prc_pkg::*;

    typedef struct packed {
        logic rst;
        logic ack;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  port_idle;
    logic  pulse_done;

    prc_drain_tracker #(.CNT_W(CNT_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_i   (ctl_q.rst),
        .issue_i  (req_issue_i),
        .done_i   (req_done_i),
        .accept_o (req_accept_o),
        .idle_o   (port_idle)
    );

    prc_pulse_timer #(.MIN_PULSE(MIN_PULSE)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_i    (ctl_q.rst),
        .elapsed_o (pulse_done)
    );

    prc_mmio_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
        .block_i      (ctl_q.rst),
        .host_rd_i    (host_rd_i),
        .host_wr_i    (host_wr_i),
        .host_addr_i  (host_addr_i),
        .host_wdata_i (host_wdata_i),
        .host_rdata_o (host_rdata_o),
        .acc_rd_o     (acc_rd_o),
        .acc_wr_o     (acc_wr_o),
        .acc_addr_o   (acc_addr_o),
        .acc_wdata_o  (acc_wdata_o),
        .acc_rdata_i  (acc_rdata_i)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.rst = csr_wr_i ? csr_wdata_i[CTRL_RST_POS] : ctl_q.rst;
        ctl_d.ack = ctl_d.rst && ctl_q.rst && pulse_done && port_idle;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{rst: 1'b1, ack: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign csr_rdata_o = ctrl_word(ctl_q.rst, ctl_q.ack);
    assign acc_rst_o   = ctl_q.rst;

    assert_rst_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr_i |=> (acc_rst_o == $past(csr_wdata_i[CTRL_RST_POS])));

    assert_ack_only_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata_o[CTRL_ACK_POS] |-> acc_rst_o);

    assert_ack_after_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.ack) |-> ($past(port_idle) && $past(pulse_done)));

    assert_ack_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr_i && !csr_wdata_i[CTRL_RST_POS]) |=> !csr_rdata_o[CTRL_ACK_POS]);

    assert_no_accept_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rst_o |-> !req_accept_o);

    assert_mmio_fenced_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rst_o |-> (!acc_rd_o && !acc_wr_o && host_rdata_o == '0));

endmodule

// File: tb/sim_port_rst_ctrl.sv
module sim_port_rst_ctrl;

    localparam int MIN  = 16;
    localparam int CW   = 4;
    localparam int MAXO = (1 << CW) - 1;
    localparam int AW   = 12;
    localparam int DW   = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_wr = 1'b0;
    logic [63:0]   csr_wdata = '0;
    logic [63:0]   csr_rdata;
    logic          issue = 1'b0, done = 1'b0, accept;
    logic          h_rd = 1'b0, h_wr = 1'b0;
    logic [AW-1:0] h_addr = '0;
    logic [DW-1:0] h_wdata = '0, h_rdata;
    logic          a_rd, a_wr, a_rst;
    logic [AW-1:0] a_addr;
    logic [DW-1:0] a_wdata;
    logic [DW-1:0] a_rdata = '0;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    bit m_rst = 1, m_ack = 0;
    int m_out = 0, m_held = 0;

    always #4 clk = ~clk;

    port_rst_ctrl #(.MIN_PULSE(MIN), .CNT_W(CW), .ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .csr_wr_i(csr_wr), .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
        .req_issue_i(issue), .req_done_i(done), .req_accept_o(accept),
        .host_rd_i(h_rd), .host_wr_i(h_wr), .host_addr_i(h_addr),
        .host_wdata_i(h_wdata), .host_rdata_o(h_rdata),
        .acc_rd_o(a_rd), .acc_wr_o(a_wr), .acc_addr_o(a_addr),
        .acc_wdata_o(a_wdata), .acc_rdata_i(a_rdata), .acc_rst_o(a_rst)
    );

    // behavioural reference of the port state
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_rst = 1; m_ack = 0; m_out = 0; m_held = 0;
        end else begin
            bit nr;
            bit acc;
            bit na;
            nr  = csr_wr ? csr_wdata[0] : m_rst;
            acc = issue && !m_rst && (m_out < MAXO);
            na  = nr && m_rst && (m_held >= MIN) && (m_out == 0);
            if (done && m_out > 0) m_out = m_out - 1;
            if (acc) m_out = m_out + 1;
            if (!m_rst) m_held = 0;
            else if (m_held < MIN) m_held = m_held + 1;
            m_rst = nr;
            m_ack = na;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_word();
        logic [63:0] w;
        w = '0; w[0] = m_rst; w[4] = m_ack;
        return w;
    endfunction

    task automatic compare_all();
        logic [DW-1:0] er;
        bit ea;
        er = m_rst ? '0 : a_rdata;
        ea = issue && !m_rst && (m_out < MAXO);
        chk(csr_rdata == exp_word(), "R3 control word", csr_rdata, exp_word());
        chk(a_rst == m_rst, "R2 acc_rst_o", 64'(a_rst), 64'(m_rst));
        chk(accept == ea, "R6 req_accept_o", 64'(accept), 64'(ea));
        chk(h_rdata == er, "R10 host_rdata_o", h_rdata, er);
        chk(a_rd == (h_rd && !m_rst) && a_wr == (h_wr && !m_rst), "R10 acc strobes",
            {a_rd, a_wr}, {(h_rd && !m_rst), (h_wr && !m_rst)});
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        compare_all();
    endtask

    task automatic csr_write(input logic [63:0] v);
        csr_wr = 1'b1; csr_wdata = v;
        step();
        csr_wr = 1'b0; csr_wdata = '0;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int got;
        steps(2);
        // R1 reset state
        chk(csr_rdata == 64'h1, "R1 reset word", csr_rdata, 64'h1);
        chk(a_rst == 1'b1, "R1 acc_rst_o", 64'(a_rst), 64'h1);
        #1 rst_n = 1'b1;
        steps(MIN + 2);
        chk(csr_rdata == 64'h11, "R4 ack after power-on pulse", csr_rdata, 64'h11);

        // R7 R8: clear reset while writing 1 into the ack position
        csr_write(64'h10);
        chk(csr_rdata == 64'h0, "R7 R8 release clears ack", csr_rdata, 64'h0);
        chk(a_rst == 1'b0, "R2 released", 64'(a_rst), 64'h0);

        // R10 pass-through
        h_rd = 1'b1; a_rdata = 64'hABC; h_addr = 12'h345; #1;
        chk(h_rdata == 64'hABC && a_rd, "R10 read passes", h_rdata, 64'hABC);
        chk(a_addr == 12'h345, "R10 address passes", 64'(a_addr), 64'h345);
        h_rd = 1'b0;

        // three outstanding requests
        issue = 1'b1; steps(3); issue = 1'b0;

        // R4 exact edge with drain pending -> R5
        csr_write(64'h1);
        issue = 1'b1; #1;
        chk(accept == 1'b0, "R6 no accept in reset", 64'(accept), 64'h0);
        issue = 1'b0;
        h_rd = 1'b1; h_wr = 1'b1; #1;
        chk(h_rdata == 64'h0 && !a_rd && !a_wr, "R10 fenced", h_rdata, 64'h0);
        h_rd = 1'b0; h_wr = 1'b0;
        steps(MIN + 3);
        chk(csr_rdata == 64'h1, "R5 no ack while outstanding", csr_rdata, 64'h1);
        done = 1'b1; steps(3); done = 1'b0;
        chk(csr_rdata == 64'h1, "R5 ack waits for count zero", csr_rdata, 64'h1);
        step();
        chk(csr_rdata == 64'h11, "R5 ack after drain", csr_rdata, 64'h11);

        // R8 R9: rewrite 1 with ack bit clear, ack must stay
        csr_write(64'hFFFF_FFFF_FFFF_FFE1);
        chk(csr_rdata == 64'h11, "R9 R8 rewrite keeps ack", csr_rdata, 64'h11);

        // R9 restart on re-entry, R4 exact edge
        csr_write(64'h0);
        csr_write(64'h1);
        steps(MIN);
        chk(csr_rdata == 64'h1, "R4 ack not before edge", csr_rdata, 64'h1);
        step();
        chk(csr_rdata == 64'h11, "R4 ack at exact edge", csr_rdata, 64'h11);
        csr_write(64'h0);
        csr_write(64'h1);
        steps(5);
        csr_write(64'h0);
        csr_write(64'h1);
        steps(MIN - 1);
        chk(csr_rdata == 64'h1, "R9 timer restarted", csr_rdata, 64'h1);

        // R11: completion on empty count is ignored
        csr_write(64'h0);
        done = 1'b1; steps(2); done = 1'b0;
        csr_write(64'h1);
        steps(MIN + 1);
        chk(csr_rdata == 64'h11, "R11 no underflow", csr_rdata, 64'h11);

        // R6: full count refuses requests
        csr_write(64'h0);
        got = 0;
        issue = 1'b1;
        for (int i = 0; i < MAXO + 2; i++) begin
            #1;
            if (accept) got++;
            step();
        end
        #1;
        chk(accept == 1'b0, "R6 full refuses", 64'(accept), 64'h0);
        chk(got == MAXO, "R6 accepted count", 64'(got), 64'(MAXO));
        issue = 1'b0;
        csr_write(64'h1);
        done = 1'b1; steps(MAXO); done = 1'b0;
        steps(2);
        chk(csr_rdata == 64'h11, "R5 ack after full drain", csr_rdata, 64'h11);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule